// File: doc/BRIEF.md
# Management-Interface Register Access Master

This block carries out single register reads and writes to an external PHY over a two-wire serial management link. The link has a clock the block drives and a shared data line. The data line is modelled as three separate signals: a value, an output enable and a returned input. A host presents one request with a direction flag, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block then sends a run of idle ones, the command frame and, for a read, the reply phase. When the access ends it pulses `done`. After a read it also presents the returned word and a flag that says whether the PHY failed to acknowledge.

The management clock comes from the system clock through a half-period divider. Each half of the management clock lasts `halfPeriod + 1` system cycles. The divider value is captured when a request is accepted. A read drives only the command header, then releases the line for the turnaround and the 16 reply bits. Every access ends with one clock cycle in which the line is released, so the line is always left undriven.

Top module: `mdio_master`

## Requirements
- R1: While reset is active and after reset is released, `mdc`, `mdioOe`, `busy`, `done`, `ackFail` are 0 and `rdData` is 0.
- R2: Every access starts with 32 consecutive one bits driven on the data line, one bit per management clock cycle.
- R3: A write then drives a 32-bit frame, most significant bit first. The frame is: start 01, opcode 01, PHY address in frame bits 27:23, register address in bits 22:18, turnaround 10, then the 16 data bits. That gives 64 driven rising clock edges in total.
- R4: A read then drives only the 14-bit header: start 01, opcode 10, PHY address, register address. That gives 46 driven rising clock edges in total.
- R5: Each management clock half lasts `halfPeriod + 1` system clock cycles. Each bit is driven while the clock is low and stays unchanged while the clock is high.
- R6: After the last driven bit, one more clock-low half follows in which the last value is still driven. Only after that half is the output enable removed.
- R7: In a read, the block first runs one released clock cycle and samples the acknowledge bit at the end of its high half. It then clocks in 16 bits with the line released, sampling each bit at the end of the high half. The first bit received becomes bit 15 of `rdData`.
- R8: If the sampled acknowledge bit is 1, `rdData` is 16'hFFFF and `ackFail` is 1, whatever bits were received. If the acknowledge bit is 0, `ackFail` is 0.
- R9: Every access ends with one released clock cycle. A write therefore has exactly 1 rising clock edge with the line released, and a read has 18. Outside an access `mdioOe` and `mdc` are 0.
- R10: `done` is a one-cycle pulse at the end of each access, and `busy` is 0 in that cycle. A request is accepted in any cycle where `busy` is 0, including the `done` cycle. A request presented while `busy` is 1 has no effect.
- R11: A write leaves `rdData` and `ackFail` at the values from the last read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqRead | input | 1 | 1 = read, 0 = write |
| reqPhy | input | 5 | PHY address |
| reqReg | input | 5 | Register address |
| reqWrData | input | 16 | Write data |
| halfPeriod | input | DIV_W | Management clock half period minus one, in system cycles |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rdData | output | 16 | Last read result |
| ackFail | output | 1 | Last read saw no acknowledge |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data line value when driven |
| mdioOe | output | 1 | Data line output enable |
| mdioIn | input | 1 | Data line as seen at the pin |

## Verification
The end-of-access pulse and the acceptance of the next request can happen in the same cycle, because the controller is already idle when `done` is high. The bench provokes this by holding `reqValid` high across the end of one read. It then checks that `busy` rises in the cycle right after `done`, that `rdData` is valid in the `done` cycle, and that the second access runs its full preamble. A separate scenario presents a different request in the middle of a write. It then checks that the captured frame, the single `done` pulse and the idle line afterwards all belong to the first request.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 32;
  localparam int HDR_BITS   = 14;
  localparam int DATA_BITS  = 16;
  localparam int SR_BITS    = PRE_BITS + FRAME_BITS;
  localparam int CNT_W      = $clog2(SR_BITS + 1);

  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] TURN_WRITE = 2'b10;

  typedef enum logic [2:0] {
    S_IDLE, S_SHIFT, S_HOLD, S_TURN, S_DATA, S_FINAL
  } mdio_state_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic sampleAck;
    logic sampleBit;
    logic finish;
  } mdio_strobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqRead,
  input  logic [DIV_W-1:0] halfPeriod,
  output mdio_strobe_t     strobe,
  output logic             mdc,
  output logic             mdioOe,
  output logic             busy,
  output logic             done
);
  mdio_state_t       state;
  logic              hi;
  logic              readQ;
  logic [DIV_W-1:0]  halfCnt;
  logic [DIV_W-1:0]  divQ;
  logic [CNT_W-1:0]  bitsLeft;
  logic              phaseEnd;
  logic              endHigh;

  assign phaseEnd = (state != S_IDLE) && (halfCnt == divQ);
  assign endHigh  = phaseEnd && hi;

  always_comb begin
    strobe           = '0;
    strobe.load      = (state == S_IDLE) && reqValid;
    strobe.shift     = (state == S_SHIFT) && endHigh && (bitsLeft != CNT_W'(1));
    strobe.sampleAck = (state == S_TURN) && endHigh;
    strobe.sampleBit = (state == S_DATA) && endHigh;
    strobe.finish    = (state == S_FINAL) && endHigh;
  end

  assign mdc    = hi;
  assign mdioOe = (state == S_SHIFT) || (state == S_HOLD);
  assign busy   = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfCnt <= '0;
    end else if (state == S_IDLE || phaseEnd) begin
      halfCnt <= '0;
    end else begin
      halfCnt <= halfCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      hi       <= 1'b0;
      readQ    <= 1'b0;
      divQ     <= '0;
      bitsLeft <= '0;
      done     <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.load) begin
        state    <= S_SHIFT;
        hi       <= 1'b0;
        readQ    <= reqRead;
        divQ     <= halfPeriod;
        bitsLeft <= reqRead ? CNT_W'(PRE_BITS + HDR_BITS) : CNT_W'(SR_BITS);
      end else if (phaseEnd) begin
        unique case (state)
          S_SHIFT: begin
            hi <= ~hi;
            if (hi) begin
              if (bitsLeft == CNT_W'(1)) state <= S_HOLD;
              else bitsLeft <= bitsLeft - CNT_W'(1);
            end
          end
          S_HOLD: begin
            state <= readQ ? S_TURN : S_FINAL;
          end
          S_TURN: begin
            hi <= ~hi;
            if (hi) begin
              state    <= S_DATA;
              bitsLeft <= CNT_W'(DATA_BITS);
            end
          end
          S_DATA: begin
            hi <= ~hi;
            if (hi) begin
              if (bitsLeft == CNT_W'(1)) state <= S_FINAL;
              else bitsLeft <= bitsLeft - CNT_W'(1);
            end
          end
          S_FINAL: begin
            hi <= ~hi;
            if (hi) state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  mdio_strobe_t         strobe,
  input  logic                 reqRead,
  input  logic [4:0]           reqPhy,
  input  logic [4:0]           reqReg,
  input  logic [DATA_BITS-1:0] reqWrData,
  input  logic                 mdioIn,
  output logic                 mdioOut,
  output logic [DATA_BITS-1:0] rdData,
  output logic                 ackFail
);
  logic [SR_BITS-1:0]    outSr;
  logic [DATA_BITS-1:0]  inSr;
  logic [FRAME_BITS-1:0] frame;
  logic                  ackBit;
  logic                  readQ;

  assign frame = {START_CODE, (reqRead ? OP_READ : OP_WRITE), reqPhy, reqReg,
                  TURN_WRITE, reqWrData};
  assign mdioOut = outSr[SR_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outSr   <= '0;
      inSr    <= '0;
      ackBit  <= 1'b0;
      readQ   <= 1'b0;
      rdData  <= '0;
      ackFail <= 1'b0;
    end else begin
      if (strobe.load) begin
        outSr <= {{PRE_BITS{1'b1}}, frame};
        readQ <= reqRead;
      end else if (strobe.shift) begin
        outSr <= {outSr[SR_BITS-2:0], 1'b0};
      end
      if (strobe.sampleAck) ackBit <= mdioIn;
      if (strobe.sampleBit) inSr <= {inSr[DATA_BITS-2:0], mdioIn};
      if (strobe.finish && readQ) begin
        rdData  <= ackBit ? {DATA_BITS{1'b1}} : inSr;
        ackFail <= ackBit;
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqRead,
  input  logic [4:0]       reqPhy,
  input  logic [4:0]       reqReg,
  input  logic [15:0]      reqWrData,
  input  logic [DIV_W-1:0] halfPeriod,
  output logic             busy,
  output logic             done,
  output logic [15:0]      rdData,
  output logic             ackFail,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  input  logic             mdioIn
);
  mdio_strobe_t strobe;

  mdio_ctrl #(.DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .halfPeriod(halfPeriod), .strobe(strobe), .mdc(mdc), .mdioOe(mdioOe),
    .busy(busy), .done(done)
  );

  mdio_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqRead(reqRead),
    .reqPhy(reqPhy), .reqReg(reqReg), .reqWrData(reqWrData), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .rdData(rdData), .ackFail(ackFail)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic [15:0] rdData,
  input logic        ackFail,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe
);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r2_start_preamble: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (mdioOe && mdioOut && !mdc));
  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdioOe && !mdc));
  a_r5_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc) && mdioOe) |-> $stable(mdioOut));
  a_r8_fail_all_ones: assert property (@(posedge clk) disable iff (!rstN)
    ackFail |-> (rdData == 16'hFFFF));
endmodule

bind mdio_master mdio_master_chk chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .rdData(rdData),
  .ackFail(ackFail), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqRead = 1'b0;
  logic [4:0] reqPhy = '0, reqReg = '0;
  logic [15:0] reqWrData = '0;
  logic [DIV_W-1:0] halfPeriod = '0;
  logic busy, done, ackFail, mdc, mdioOut, mdioOe;
  logic [15:0] rdData;
  logic mdioIn = 1'b1;

  int checks = 0, errors = 0;
  logic [63:0] capBits;
  int capCount, triCount;
  logic [17:0] resp;
  time lastRise, lastFall, highW, holdW;

  always #10 clk = ~clk;

  mdio_master #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .reqPhy(reqPhy), .reqReg(reqReg), .reqWrData(reqWrData),
    .halfPeriod(halfPeriod), .busy(busy), .done(done), .rdData(rdData),
    .ackFail(ackFail), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(mdioIn)
  );

  // PHY-side model: captures driven bits, answers in released cycles
  always @(posedge mdc) begin
    lastRise = $time;
    if (mdioOe) begin
      capBits = {capBits[62:0], mdioOut};
      capCount++;
    end else begin
      if (triCount < 18) mdioIn <= resp[17 - triCount];
      triCount++;
    end
  end
  always @(negedge mdc) begin
    lastFall = $time;
    highW = $time - lastRise;
  end
  always @(negedge mdioOe) holdW = $time - lastFall;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic clearMon(input logic [17:0] r);
    capBits = '0; capCount = 0; triCount = 0; resp = r; mdioIn = 1'b1;
  endtask

  task automatic issue(input bit rd, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] d, input logic [DIV_W-1:0] hp);
    @(negedge clk);
    reqValid = 1'b1; reqRead = rd; reqPhy = p; reqReg = r; reqWrData = d;
    halfPeriod = hp;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(output int doneCnt);
    doneCnt = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin
        doneCnt++;
        break;
      end
    end
  endtask

  task automatic testReset;
    @(negedge clk);
    check(!mdc && !mdioOe && !busy && !done, "R1", "idle outputs in reset",
          {mdc, mdioOe, busy, done}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!mdc && !mdioOe && !busy && !done && !ackFail && rdData == 0, "R1",
          "idle after reset", {ackFail, rdData}, 0);
  endtask

  task automatic testWrite(input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] d, input logic [DIV_W-1:0] hp);
    int dc;
    logic [63:0] exp;
    logic [15:0] oldRd;
    logic oldFail;
    oldRd = rdData; oldFail = ackFail;
    clearMon('1);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
    issue(1'b0, p, r, d, hp);
    waitDone(dc);
    check(dc == 1, "R10", "write done seen", dc, 1);
    check(capCount == 64, "R3", "write driven edges", capCount, 64);
    check(capBits == exp, "R3", "write frame bits (R2 preamble)", capBits, exp);
    check(triCount == 1, "R9", "write released edges", triCount, 1);
    check(highW == (hp + 1) * 20, "R5", "high half length", highW, (hp + 1) * 20);
    check(holdW == (hp + 1) * 20, "R6", "hold after last bit", holdW, (hp + 1) * 20);
    check(!mdioOe && !busy, "R9", "line released at done", {mdioOe, busy}, 0);
    check(rdData == oldRd && ackFail == oldFail, "R11", "write keeps read result",
          {ackFail, rdData}, {oldFail, oldRd});
  endtask

  task automatic testRead(input logic [4:0] p, input logic [4:0] r,
                          input bit ack, input logic [15:0] d,
                          input logic [DIV_W-1:0] hp);
    int dc;
    logic [45:0] exp;
    logic [15:0] expRd;
    clearMon({ack, d, 1'b1});
    exp = {32'hFFFF_FFFF, 2'b01, 2'b10, p, r};
    expRd = ack ? 16'hFFFF : d;
    issue(1'b1, p, r, 16'h0, hp);
    waitDone(dc);
    check(dc == 1, "R10", "read done seen", dc, 1);
    check(capCount == 46, "R4", "read driven edges", capCount, 46);
    check(capBits[45:0] == exp, "R4", "read header bits", capBits[45:0], exp);
    check(triCount == 18, "R9", "read released edges", triCount, 18);
    check(holdW == (hp + 1) * 20, "R6", "hold after header", holdW, (hp + 1) * 20);
    check(rdData == expRd, ack ? "R8" : "R7", "read data", rdData, expRd);
    check(ackFail == ack, "R8", "ack fail flag", ackFail, ack);
  endtask

  task automatic testIgnoreBusy;
    int dc;
    logic [63:0] exp;
    clearMon('1);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h0A, 5'h15, 2'b10, 16'h0F0F};
    issue(1'b0, 5'h0A, 5'h15, 16'h0F0F, 8'd1);
    repeat (40) @(negedge clk);
    issue(1'b1, 5'h1F, 5'h1F, 16'hFFFF, 8'd0);
    waitDone(dc);
    check(capBits == exp && capCount == 64, "R10", "request during busy ignored",
          capBits, exp);
    repeat (30) @(negedge clk);
    check(!busy && capCount == 64, "R10", "no second access started",
          {busy, capCount}, 64);
  endtask

  task automatic testBackToBack;
    int dc;
    clearMon({1'b0, 16'h5A5A, 1'b1});
    @(negedge clk);
    reqValid = 1'b1; reqRead = 1'b1; reqPhy = 5'h03; reqReg = 5'h04;
    halfPeriod = 8'd0;
    waitDone(dc);
    check(rdData == 16'h5A5A, "R7", "data valid in done cycle", rdData, 16'h5A5A);
    @(negedge clk);
    check(busy, "R10", "accept in done cycle", busy, 1);
    reqValid = 1'b0;
    resp = {1'b0, 16'h3C3C, 1'b1}; triCount = 0;
    waitDone(dc);
    check(dc == 1 && capCount == 92, "R2", "second access full preamble+header",
          capCount, 92);
    check(rdData == 16'h3C3C, "R7", "second read data", rdData, 16'h3C3C);
  endtask

  initial begin
    fork
      begin
        testReset();
        testWrite(5'h01, 5'h02, 16'hBEEF, 8'd1);
        testWrite(5'h1F, 5'h00, 16'h8001, 8'd0);
        testRead(5'h11, 5'h0C, 1'b0, 16'hA5C3, 8'd2);
        testRead(5'h05, 5'h1E, 1'b1, 16'h1234, 8'd1);
        testWrite(5'h00, 5'h1F, 16'h0000, 8'd3);
        testBackToBack();
        testIgnoreBusy();
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule